// File: doc/BRIEF.md
# Inter-Processor Interrupt Agent Matrix

This block lets eleven processing agents signal one another through registers. Each agent owns a small window of registers. When a sender writes a one-hot target pattern into its own trigger register, the sender's bit becomes pending in the status register of each agent it named. The receiver acknowledges by writing ones back to its status register. While the receiver has not acknowledged, the sender can read the same bit in its observation register and poll it to learn when the message has been taken.

Each agent also has a mask. The mask is changed only through separate write-only enable and disable registers, so a single bit can be changed without a read-modify-write. Each agent drives one registered interrupt line. Some agents are secure-only. Non-secure requesters may not touch their windows or signal them. Two independent requester ports share the matrix. This lets a trigger and an acknowledge to the same bit land in the same cycle, and the block resolves that case deterministically.

Top module: `ipi_mesh`

## Requirements
- R1: Byte address bits [11:8] select the agent window (0 to 10), and bits [7:0] select the register: 0x00 trigger, 0x04 observation, 0x10 status, 0x14 mask, 0x18 enable, 0x1C disable. The read data and the error flag of an access appear one clock after the request.
- R2: In every 32-bit register, agents 0 to 10 use bit positions 0, 8, 9, 16, 17, 18, 19, 24, 25, 26 and 27 in that order. All other bits read as zero, and writes to them are ignored.
- R3: When window s receives a trigger write with the bit of agent t set, the bit of agent s is set in the status register of agent t.
- R4: In the observation register of agent s, the bit of agent t reads as one exactly while the bit of s is pending in the status register of t.
- R5: Writing a one to a status bit clears it. Writing a zero leaves it unchanged.
- R6: Writing a one to the enable register clears the matching mask bit, and writing a one to the disable register sets it. Reads of the trigger, enable and disable registers return zero.
- R7: After reset, every valid mask bit is set, every status and observation bit is clear, and every interrupt line is low.
- R8: An agent's interrupt line is the registered OR of its unmasked status bits. It changes one clock after the status or mask change that causes it.
- R9: Agents 3, 5 and 6 (bits 16, 18, 19) are secure-only. A non-secure access to their windows is refused. A non-secure trigger write that names any of them is also refused.
- R10: A refused access, or an access to agent 11 or above or to an undefined offset, returns the error flag with read data zero and changes no state.
- R11: The two ports act in the same cycle. A trigger wins over a clear of the same status bit, and a disable wins over an enable of the same mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 2 | Per-port access request |
| req_write | input | 2 | Per-port write (1) or read (0) |
| req_addr | input | 24 | Per-port 12-bit byte address, port p at [p*12 +: 12] |
| req_wdata | input | 64 | Per-port write data, port p at [p*32 +: 32] |
| req_secure | input | 2 | Per-port secure-requester flag |
| rsp_rdata | output | 64 | Per-port read data, one cycle after the request |
| rsp_err | output | 2 | Per-port refusal flag, one cycle after the request |
| irq_o | output | 11 | Interrupt line per agent |

## Verification
Two actions can hit the same status bit in one cycle: a sender's trigger on one port and the receiver's acknowledge on the other. The bench provokes this by issuing both requests in the same clock. It then reads the status and observation registers, and the bit must still be pending. In the same way, an enable and a disable of one mask bit are issued together, and the mask must read back with only the disabled bit set. Both results are predicted from a bench-side model of the pending and mask matrices.

// File: rtl/ipi_mesh_pkg.sv
// Package: shared register kinds, offsets and the agent-to-bit mapping.
// Assumes at most eleven agents use the fixed bit layout below.
package ipi_mesh_pkg;

    typedef enum logic [2:0] {
        RK_TRIG,
        RK_OBS,
        RK_STAT,
        RK_MASK,
        RK_EN,
        RK_DIS,
        RK_NONE
    } reg_kind_e;

    localparam int OFF_TRIG = 'h00;
    localparam int OFF_OBS  = 'h04;
    localparam int OFF_STAT = 'h10;
    localparam int OFF_MASK = 'h14;
    localparam int OFF_EN   = 'h18;
    localparam int OFF_DIS  = 'h1C;

    // Bit position of agent i inside every 32-bit register.
    function automatic int unsigned agent_bit(int unsigned i);
        if (i == 0)      return 0;
        else if (i < 3)  return 7 + i;
        else if (i < 7)  return 13 + i;
        else             return 17 + i;
    endfunction

endpackage

// File: rtl/ipi_access_check.sv
// Module: decodes one port's request into agent, register kind and the
// collapsed per-agent write vector, and decides whether it is refused.
// Assumes the agent field sits above AGENT_LSB in the byte address.
module ipi_access_check
    import ipi_mesh_pkg::*;
#(
    parameter int NUM_AGENTS = 11,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int AGENT_LSB  = 8,
    parameter logic [NUM_AGENTS-1:0] SECURE_AGENTS = 11'h068,
    localparam int AW = ADDR_W - AGENT_LSB
) (
    input  logic                  valid_i,
    input  logic                  write_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  secure_i,
    output logic                  ok_o,
    output logic                  err_o,
    output reg_kind_e             kind_o,
    output logic [AW-1:0]         agent_o,
    output logic [NUM_AGENTS-1:0] wvec_o
);

    logic [AGENT_LSB-1:0] offset;
    logic                 in_range;
    logic                 sec_window;
    logic                 sec_target;
    logic                 refuse;

    assign agent_o = addr_i[ADDR_W-1:AGENT_LSB];
    assign offset  = addr_i[AGENT_LSB-1:0];

    // Collapse the data word onto one bit per agent.
    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_wvec
        assign wvec_o[i] = wdata_i[agent_bit(i)];
    end

    // Purpose: map the offset onto a register kind.
    always_comb begin
        if (offset == AGENT_LSB'(OFF_TRIG))      kind_o = RK_TRIG;
        else if (offset == AGENT_LSB'(OFF_OBS))  kind_o = RK_OBS;
        else if (offset == AGENT_LSB'(OFF_STAT)) kind_o = RK_STAT;
        else if (offset == AGENT_LSB'(OFF_MASK)) kind_o = RK_MASK;
        else if (offset == AGENT_LSB'(OFF_EN))   kind_o = RK_EN;
        else if (offset == AGENT_LSB'(OFF_DIS))  kind_o = RK_DIS;
        else                                     kind_o = RK_NONE;
    end

    // Purpose: find whether the addressed window belongs to a secure agent.
    always_comb begin
        in_range   = 1'b0;
        sec_window = 1'b0;
        for (int a = 0; a < NUM_AGENTS; a++) begin
            if (agent_o == AW'(a)) begin
                in_range   = 1'b1;
                sec_window = SECURE_AGENTS[a];
            end
        end
    end

    assign sec_target = write_i && (kind_o == RK_TRIG) && |(wvec_o & SECURE_AGENTS);
    assign refuse     = !in_range || (kind_o == RK_NONE) ||
                        (!secure_i && (sec_window || sec_target));
    assign ok_o       = valid_i && !refuse;
    assign err_o      = valid_i && refuse;

endmodule

// File: rtl/ipi_pend_array.sv
// Module: holds the pending matrix (target x sender), the mask matrix and
// the registered interrupt lines. Set wins over clear for pending bits,
// and set (disable) wins over clear (enable) for mask bits.
module ipi_pend_array #(
    parameter int NUM_AGENTS = 11
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] set_i,
    input  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] clr_i,
    input  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] mset_i,
    input  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] mclr_i,
    output logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] pend_o,
    output logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] mask_o,
    output logic [NUM_AGENTS-1:0]                 irq_o
);

    // Purpose: update pending, mask and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= '0;
            mask_o <= '1;
            irq_o  <= '0;
        end else begin
            pend_o <= (pend_o & ~clr_i) | set_i;
            mask_o <= (mask_o & ~mclr_i) | mset_i;
            for (int t = 0; t < NUM_AGENTS; t++) begin
                irq_o[t] <= |(pend_o[t] & ~mask_o[t]);
            end
        end
    end

    // R11: a requested set is pending on the next cycle even if also cleared.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R5: a clear without a competing set removes the bit.
    a_r5_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

    // R11: a disable wins over an enable of the same mask bit.
    a_r11_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mset_i != '0) |=> ((mask_o & $past(mset_i)) == $past(mset_i)));

    for (genvar t = 0; t < NUM_AGENTS; t++) begin : g_irq_chk
        // R8: a newly unmasked pending bit raises the line one cycle later.
        a_r8_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(|(pend_o[t] & ~mask_o[t])) |=> irq_o[t]);
    end

endmodule

// File: rtl/ipi_mesh.sv
// Module: top of the interrupt matrix. Decodes each port, merges the write
// effects of all ports into set/clear vectors, and builds the registered
// read response. Assumes at most one access per port per cycle.
module ipi_mesh
    import ipi_mesh_pkg::*;
#(
    parameter int NUM_AGENTS = 11,
    parameter int NUM_PORTS  = 2,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int AGENT_LSB  = 8,
    parameter logic [NUM_AGENTS-1:0] SECURE_AGENTS = 11'h068
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS-1:0]           req_valid,
    input  logic [NUM_PORTS-1:0]           req_write,
    input  logic [NUM_PORTS*ADDR_W-1:0]    req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]    req_wdata,
    input  logic [NUM_PORTS-1:0]           req_secure,
    output logic [NUM_PORTS*DATA_W-1:0]    rsp_rdata,
    output logic [NUM_PORTS-1:0]           rsp_err,
    output logic [NUM_AGENTS-1:0]          irq_o
);

    localparam int AW = ADDR_W - AGENT_LSB;

    logic [NUM_PORTS-1:0]   acc_ok;
    logic [NUM_PORTS-1:0]   acc_err;
    reg_kind_e              kind     [NUM_PORTS];
    logic [AW-1:0]          agent_ix [NUM_PORTS];
    logic [NUM_AGENTS-1:0]  wvec     [NUM_PORTS];
    logic [NUM_AGENTS-1:0]  rd_vec   [NUM_PORTS];
    logic [DATA_W-1:0]      rd_word  [NUM_PORTS];
    logic [DATA_W-1:0]      valid_bits;

    logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] set_v, clr_v, mset_v, mclr_v;
    logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] pend, mask;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ipi_access_check #(
            .NUM_AGENTS   (NUM_AGENTS),
            .ADDR_W       (ADDR_W),
            .DATA_W       (DATA_W),
            .AGENT_LSB    (AGENT_LSB),
            .SECURE_AGENTS(SECURE_AGENTS)
        ) u_check (
            .valid_i (req_valid[p]),
            .write_i (req_write[p]),
            .addr_i  (req_addr[p*ADDR_W +: ADDR_W]),
            .wdata_i (req_wdata[p*DATA_W +: DATA_W]),
            .secure_i(req_secure[p]),
            .ok_o    (acc_ok[p]),
            .err_o   (acc_err[p]),
            .kind_o  (kind[p]),
            .agent_o (agent_ix[p]),
            .wvec_o  (wvec[p])
        );
    end

    // Purpose: merge the write effects of every accepted port access.
    always_comb begin
        set_v  = '0;
        clr_v  = '0;
        mset_v = '0;
        mclr_v = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int a = 0; a < NUM_AGENTS; a++) begin
                if (acc_ok[p] && req_write[p] && agent_ix[p] == AW'(a)) begin
                    case (kind[p])
                        RK_TRIG: for (int t = 0; t < NUM_AGENTS; t++)
                                     set_v[t][a] = set_v[t][a] | wvec[p][t];
                        RK_STAT: clr_v[a]  = clr_v[a]  | wvec[p];
                        RK_EN:   mclr_v[a] = mclr_v[a] | wvec[p];
                        RK_DIS:  mset_v[a] = mset_v[a] | wvec[p];
                        default: ;
                    endcase
                end
            end
        end
    end

    ipi_pend_array #(
        .NUM_AGENTS(NUM_AGENTS)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .mset_i(mset_v),
        .mclr_i(mclr_v),
        .pend_o(pend),
        .mask_o(mask),
        .irq_o (irq_o)
    );

    // Purpose: select the per-agent read vector and spread it onto the word.
    always_comb begin
        valid_bits = '0;
        for (int i = 0; i < NUM_AGENTS; i++) valid_bits[agent_bit(i)] = 1'b1;
        for (int p = 0; p < NUM_PORTS; p++) begin
            rd_vec[p] = '0;
            for (int a = 0; a < NUM_AGENTS; a++) begin
                if (agent_ix[p] == AW'(a)) begin
                    case (kind[p])
                        RK_OBS:  for (int t = 0; t < NUM_AGENTS; t++)
                                     rd_vec[p][t] = pend[t][a];
                        RK_STAT: rd_vec[p] = pend[a];
                        RK_MASK: rd_vec[p] = mask[a];
                        default: rd_vec[p] = '0;
                    endcase
                end
            end
            rd_word[p] = '0;
            for (int i = 0; i < NUM_AGENTS; i++) rd_word[p][agent_bit(i)] = rd_vec[p][i];
        end
    end

    // Purpose: register the per-port response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                rsp_err[p] <= acc_err[p];
                rsp_rdata[p*DATA_W +: DATA_W] <=
                    (acc_ok[p] && !req_write[p]) ? rd_word[p] : '0;
            end
        end
    end

    // R10: refused accesses alone leave pending and mask state untouched.
    a_r10_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_err != '0) && ((acc_ok & req_write) == '0))
            |=> ($stable(pend) && $stable(mask)));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp_chk
        // R2: no read ever shows a bit outside the agent positions.
        a_r2_valid_bits_only: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_rdata[p*DATA_W +: DATA_W] & ~valid_bits) == '0);
        // R10: an error response carries zero data.
        a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_err[p] |-> (rsp_rdata[p*DATA_W +: DATA_W] == '0));
    end

endmodule

// File: tb/ipi_mesh_tb.sv
module ipi_mesh_tb;

    localparam int N  = 11;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] req_valid = '0;
    logic [NP-1:0] req_write = '0;
    logic [NP*12-1:0] req_addr = '0;
    logic [NP*32-1:0] req_wdata = '0;
    logic [NP-1:0] req_secure = '0;
    logic [NP*32-1:0] rsp_rdata;
    logic [NP-1:0] rsp_err;
    logic [N-1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit ep [N][N];  // ep[target][sender]
    bit em [N][N];  // em[agent][bit-of-agent]

    always #10 clk = ~clk;

    ipi_mesh u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_secure(req_secure),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_o(irq_o)
    );

    function automatic int bpos(int i);
        if (i == 0) return 0;
        if (i <= 2) return 8 + (i - 1);
        if (i <= 6) return 16 + (i - 3);
        return 24 + (i - 7);
    endfunction

    function automatic logic [31:0] vmask();
        logic [31:0] v = '0;
        for (int i = 0; i < N; i++) v[bpos(i)] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] m_stat(int t);
        logic [31:0] v = '0;
        for (int s = 0; s < N; s++) if (ep[t][s]) v[bpos(s)] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] m_obs(int s);
        logic [31:0] v = '0;
        for (int t = 0; t < N; t++) if (ep[t][s]) v[bpos(t)] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] m_mask(int a);
        logic [31:0] v = '0;
        for (int i = 0; i < N; i++) if (em[a][i]) v[bpos(i)] = 1'b1;
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(int p, bit wr, int agent, int off, logic [31:0] d, bit sec,
                        output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid[p] = 1'b1;
        req_write[p] = wr;
        req_addr[p*12 +: 12] = 12'((agent << 8) | off);
        req_wdata[p*32 +: 32] = d;
        req_secure[p] = sec;
        @(negedge clk);
        rd = rsp_rdata[p*32 +: 32];
        er = rsp_err[p];
        req_valid[p] = 1'b0;
        req_write[p] = 1'b0;
    endtask

    task automatic rd_chk(string req, int agent, int off, logic [31:0] exp);
        logic [31:0] rd; logic er;
        xfer(0, 1'b0, agent, off, 32'h0, 1'b1, rd, er);
        chk(req, rd, exp);
    endtask

    task automatic wr_ok(int p, int agent, int off, logic [31:0] d);
        logic [31:0] rd; logic er;
        xfer(p, 1'b1, agent, off, d, 1'b1, rd, er);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic er;
        for (int t = 0; t < N; t++)
            for (int s = 0; s < N; s++) begin ep[t][s] = 0; em[t][s] = 1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state
        for (int a = 0; a < N; a++) begin
            rd_chk("R7 mask after reset", a, 'h14, vmask());
            rd_chk("R7 status after reset", a, 'h10, 32'h0);
            rd_chk("R7 obs after reset", a, 'h04, 32'h0);
        end
        chk("R7 irq after reset", 32'(irq_o), 32'h0);

        // R3 R4 R5: exhaustive sender/target sweep
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                wr_ok(0, s, 'h00, 32'h1 << bpos(t));
                ep[t][s] = 1;
                rd_chk("R3 status after trigger", t, 'h10, m_stat(t));
                rd_chk("R4 obs while pending", s, 'h04, m_obs(s));
                wr_ok(1, t, 'h10, 32'h1 << bpos(s));
                ep[t][s] = 0;
                rd_chk("R4 obs after ack", s, 'h04, m_obs(s));
            end
        end
        chk("R8 masked lines stay low", 32'(irq_o), 32'h0);

        // R2 R5: all-ones trigger touches only agent bits; zero write no effect
        wr_ok(0, 4, 'h00, 32'hFFFF_FFFF);
        for (int t = 0; t < N; t++) ep[t][4] = 1;
        rd_chk("R2 obs of all-ones trigger", 4, 'h04, vmask());
        for (int t = 0; t < N; t++) rd_chk("R2 status after all-ones", t, 'h10, m_stat(t));
        wr_ok(0, 2, 'h10, 32'h0);
        rd_chk("R5 zero write keeps status", 2, 'h10, m_stat(2));
        // R6: write-only registers read zero
        rd_chk("R6 trigger reads zero", 4, 'h00, 32'h0);
        rd_chk("R6 enable reads zero", 4, 'h18, 32'h0);
        rd_chk("R6 disable reads zero", 4, 'h1C, 32'h0);
        for (int t = 0; t < N; t++) begin
            wr_ok(0, t, 'h10, 32'hFFFF_FFFF);
            ep[t][4] = 0;
        end
        rd_chk("R5 obs after all acks", 4, 'h04, 32'h0);

        // R6 R8: enable, latency, mask, re-enable
        wr_ok(0, 2, 'h18, 32'hFFFF_FFFF);
        for (int i = 0; i < N; i++) em[2][i] = 0;
        rd_chk("R6 mask after enable", 2, 'h14, m_mask(2));
        xfer(0, 1'b1, 0, 'h00, 32'h1 << bpos(2), 1'b1, rd, er);
        ep[2][0] = 1;
        chk("R8 irq not yet raised", 32'(irq_o[2]), 32'h0);
        @(negedge clk);
        chk("R8 irq raised one cycle later", 32'(irq_o[2]), 32'h1);
        wr_ok(0, 2, 'h1C, 32'h1 << bpos(0));
        em[2][0] = 1;
        rd_chk("R6 mask after disable", 2, 'h14, m_mask(2));
        chk("R8 irq low when masked", 32'(irq_o[2]), 32'h0);
        wr_ok(0, 2, 'h18, 32'h1 << bpos(0));
        em[2][0] = 0;
        @(negedge clk);
        chk("R8 irq back after enable", 32'(irq_o[2]), 32'h1);
        wr_ok(0, 2, 'h10, 32'h1 << bpos(0));
        ep[2][0] = 0;
        @(negedge clk);
        chk("R8 irq falls after ack", 32'(irq_o[2]), 32'h0);

        // R9: secure-only agents
        xfer(0, 1'b0, 3, 'h14, 32'h0, 1'b0, rd, er);
        chk("R9 non-secure read refused err", 32'(er), 32'h1);
        chk("R9 non-secure read data zero", rd, 32'h0);
        xfer(0, 1'b1, 5, 'h18, 32'hFFFF_FFFF, 1'b0, rd, er);
        chk("R9 non-secure enable refused", 32'(er), 32'h1);
        rd_chk("R9 secure mask unchanged", 5, 'h14, m_mask(5));
        xfer(0, 1'b1, 0, 'h00, (32'h1 << bpos(1)) | (32'h1 << bpos(3)), 1'b0, rd, er);
        chk("R9 non-secure trigger at secure refused", 32'(er), 32'h1);
        rd_chk("R10 refused trigger left status", 1, 'h10, m_stat(1));
        xfer(0, 1'b1, 0, 'h00, 32'h1 << bpos(1), 1'b0, rd, er);
        chk("R9 non-secure trigger allowed", 32'(er), 32'h0);
        ep[1][0] = 1;
        rd_chk("R9 allowed trigger pending", 1, 'h10, m_stat(1));
        wr_ok(0, 1, 'h10, 32'h1);
        ep[1][0] = 0;

        // R1 R10: out-of-range agent and bad offsets
        xfer(0, 1'b0, 11, 'h14, 32'h0, 1'b1, rd, er);
        chk("R10 agent 11 err", 32'(er), 32'h1);
        chk("R10 agent 11 data", rd, 32'h0);
        xfer(1, 1'b0, 0, 'h08, 32'h0, 1'b1, rd, er);
        chk("R1 offset 0x08 err", 32'(er), 32'h1);
        xfer(0, 1'b0, 0, 'h12, 32'h0, 1'b1, rd, er);
        chk("R1 unaligned offset err", 32'(er), 32'h1);
        xfer(0, 1'b1, 15, 'h00, 32'hFFFF_FFFF, 1'b1, rd, er);
        chk("R10 agent 15 trigger err", 32'(er), 32'h1);
        for (int t = 0; t < N; t++) rd_chk("R10 no state after bad trigger", t, 'h10, m_stat(t));
        xfer(0, 1'b0, 1, 'h14, 32'h0, 1'b1, rd, er);
        chk("R1 valid read no err", 32'(er), 32'h0);

        // R11: trigger and clear of the same bit in one cycle
        wr_ok(0, 7, 'h00, 32'h1 << bpos(9));
        ep[9][7] = 1;
        @(negedge clk);
        req_valid = 2'b11; req_write = 2'b11; req_secure = 2'b11;
        req_addr[0 +: 12]  = 12'((7 << 8) | 'h00);
        req_wdata[0 +: 32] = 32'h1 << bpos(9);
        req_addr[12 +: 12] = 12'((9 << 8) | 'h10);
        req_wdata[32 +: 32] = 32'h1 << bpos(7);
        @(negedge clk);
        req_valid = 2'b00; req_write = 2'b00;
        rd_chk("R11 trigger beats clear status", 9, 'h10, m_stat(9));
        rd_chk("R11 trigger beats clear obs", 7, 'h04, m_obs(7));
        // R11: disable and enable together
        @(negedge clk);
        req_valid = 2'b11; req_write = 2'b11;
        req_addr[0 +: 12]  = 12'((9 << 8) | 'h18);
        req_wdata[0 +: 32] = 32'hFFFF_FFFF;
        req_addr[12 +: 12] = 12'((9 << 8) | 'h1C);
        req_wdata[32 +: 32] = 32'h1 << bpos(0);
        @(negedge clk);
        req_valid = 2'b00; req_write = 2'b00;
        for (int i = 0; i < N; i++) em[9][i] = (i == 0);
        rd_chk("R11 disable beats enable", 9, 'h14, m_mask(9));
        @(negedge clk);
        chk("R8 irq for agent 9", 32'(irq_o[9]), 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule